// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the up and down pulses of the phase-frequency detector with a fast measurement clock. In every reference period it counts the measurement-clock cycles during which either pulse is high, and that count is the phase error of the period. Each error is then sorted into one of three classes. It is small when it is below the lock window, large when it is above the unlock window, and in between otherwise.

The active-high lock flag rises only after an unbroken run of small-error periods. It falls on a single large-error period or when a new channel is programmed. An in-between period breaks the run but leaves an existing lock in place, so the two windows give the flag hysteresis. A select input widens the lock window for low output frequencies, where the default window is too tight for reliable detection.

The reference-period boundary arrives as a one-cycle strobe, `period_end_i`, that is synchronous to the measurement clock. The cycle that carries the strobe is the last cycle of its period. The lock flag reflects a period two rising edges after that cycle.

Top module: `pll_lock_detect`

## Requirements
- R1: While `rst_n` is low, and after it is released, `lock_o` is 0 and the run of good periods is empty.
- R2: `lock_o` goes to 1 after 40 (`LOCK_RUN`) consecutive periods whose error is below the lock window, and not after 39.
- R3: With `wide_win_i` = 0 the lock window is 3 cycles. An error of 2 counts as good. An error of 3 is an in-between error and breaks the run.
- R4: With `wide_win_i` = 1 the lock window is 10 cycles. An error of 9 counts as good. An error of 10 breaks the run.
- R5: An error above 30 cycles (`UNLOCK_LIMIT`) clears `lock_o` and the run. An error of exactly 30 does not clear `lock_o`.
- R6: A one-cycle `chan_new_i` pulse clears `lock_o` and the run. It has priority over a period result that is evaluated in the same cycle.
- R7: An in-between error clears the run but leaves `lock_o` unchanged when it is already 1.
- R8: The error count saturates at 31 (all ones of the 5-bit width). An error that lasts longer than that is treated as large and does not wrap around to a small value.
- R9: A cycle counts toward the error when `up_i`, `dn_i` or both are high. A cycle in which both pulses overlap is counted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| up_i | input | 1 | Detector up pulse, synchronous to `clk` |
| dn_i | input | 1 | Detector down pulse, synchronous to `clk` |
| period_end_i | input | 1 | High on the last cycle of each reference period |
| wide_win_i | input | 1 | 1 selects the wide lock window |
| chan_new_i | input | 1 | One-cycle strobe that marks a channel reprogram |
| lock_o | output | 1 | Active-high lock flag |

## Verification
Two events can land in the same cycle. One is a channel reprogram strobe. The other is the evaluation of a period result, which happens one edge after that period's `period_end_i`. The bench provokes the collision by pulsing `chan_new_i` in exactly that evaluation cycle after the 40th good period. It judges the outcome by checking that `lock_o` stays 0 and that another full run of 40 good periods is then needed before lock returns. A second collision is also covered: an in-between or large error arriving while the flag is set, where the flag must hold for the in-between case and fall for the large one.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    ERR_SMALL = 2'd0,
    ERR_MID   = 2'd1,
    ERR_LARGE = 2'd2
  } err_class_t;
endpackage

// File: rtl/pld_width_meter.sv
module pld_width_meter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         period_end_i,
  output logic [W-1:0] width_o,
  output logic         width_vld_o
);
  localparam logic [W-1:0] SAT = '1;

  logic         active;
  logic [W-1:0] acc_q, acc_d, sum;
  logic [W-1:0] width_q;
  logic         vld_q;

  always_comb begin
    active = up_i | dn_i;
    if (acc_q == SAT) sum = acc_q;
    else              sum = acc_q + {{(W-1){1'b0}}, active};
    acc_d = period_end_i ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      width_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      acc_q <= acc_d;
      vld_q <= period_end_i;
      if (period_end_i) width_q <= sum;
    end
  end

  assign width_o     = width_q;
  assign width_vld_o = vld_q;

  AST_WIDTH_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_i |=> width_vld_o); // R9

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_q) == SAT && !$past(period_end_i)) |-> acc_q == SAT); // R8
endmodule

// File: rtl/pld_window_cmp.sv
module pld_window_cmp
  import pld_pkg::*;
#(
  parameter int W            = 5,
  parameter int LOCK_NARROW  = 3,
  parameter int LOCK_WIDE    = 10,
  parameter int UNLOCK_LIMIT = 30
) (
  input  logic [W-1:0] width_i,
  input  logic         wide_win_i,
  output err_class_t   class_o
);
  localparam logic [W-1:0] THR_N = W'(LOCK_NARROW);
  localparam logic [W-1:0] THR_W = W'(LOCK_WIDE);
  localparam logic [W-1:0] THR_U = W'(UNLOCK_LIMIT);

  logic [W-1:0] lock_thr;

  always_comb begin
    lock_thr = wide_win_i ? THR_W : THR_N;
    if (width_i > THR_U)         class_o = ERR_LARGE;
    else if (width_i < lock_thr) class_o = ERR_SMALL;
    else                         class_o = ERR_MID;
  end
endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm
  import pld_pkg::*;
#(
  parameter int LOCK_RUN = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eval_i,
  input  err_class_t class_i,
  input  logic       chan_new_i,
  output logic       lock_o
);
  localparam int CW = $clog2(LOCK_RUN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(LOCK_RUN);

  logic [CW-1:0] run_q, run_d;
  logic          lock_q, lock_d;
  logic          run_en;

  always_comb begin
    run_d  = run_q;
    lock_d = lock_q;
    run_en = chan_new_i | eval_i;
    if (chan_new_i) begin
      run_d  = '0;
      lock_d = 1'b0;
    end else if (eval_i) begin
      unique case (class_i)
        ERR_SMALL: begin
          if (run_q != RUN_MAX) run_d = run_q + 1'b1;
          if (run_d == RUN_MAX) lock_d = 1'b1;
        end
        ERR_MID:   run_d = '0;
        default: begin
          run_d  = '0;
          lock_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (run_en) begin
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

  AST_LOCK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> run_q == RUN_MAX); // R2
  AST_CHAN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chan_new_i |=> (!lock_q && run_q == '0)); // R6
  AST_LARGE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && class_i == ERR_LARGE) |=> !lock_q); // R5
  AST_MID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && class_i == ERR_MID && lock_q && !chan_new_i) |=> (lock_q && run_q == '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX); // R2
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pld_pkg::*;
#(
  parameter int LOCK_RUN     = 40,
  parameter int LOCK_NARROW  = 3,
  parameter int LOCK_WIDE    = 10,
  parameter int UNLOCK_LIMIT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  input  logic period_end_i,
  input  logic wide_win_i,
  input  logic chan_new_i,
  output logic lock_o
);
  localparam int W = $clog2(UNLOCK_LIMIT + 2);

  logic [W-1:0] width;
  logic         width_vld;
  err_class_t   err_class;

  pld_width_meter #(.W(W)) u_meter (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_i         (up_i),
    .dn_i         (dn_i),
    .period_end_i (period_end_i),
    .width_o      (width),
    .width_vld_o  (width_vld)
  );

  pld_window_cmp #(
    .W(W), .LOCK_NARROW(LOCK_NARROW), .LOCK_WIDE(LOCK_WIDE), .UNLOCK_LIMIT(UNLOCK_LIMIT)
  ) u_cmp (
    .width_i    (width),
    .wide_win_i (wide_win_i),
    .class_o    (err_class)
  );

  pld_lock_fsm #(.LOCK_RUN(LOCK_RUN)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_i     (width_vld),
    .class_i    (err_class),
    .chan_new_i (chan_new_i),
    .lock_o     (lock_o)
  );

  AST_RESET_UNLOCKED: assert property (@(posedge clk)
    !rst_n |=> !lock_o); // R1
endmodule

// File: tb/tb_pll_lock_detect.sv
module tb_pll_lock_detect;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n, up_i, dn_i, period_end_i, wide_win_i, chan_new_i;
  logic lock_o;
  int   n_cmp = 0;
  int   n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_lock_detect dut (
    .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i),
    .period_end_i(period_end_i), .wide_win_i(wide_win_i),
    .chan_new_i(chan_new_i), .lock_o(lock_o)
  );

  // mode: 0 up only, 1 down only, 2 up and down overlapping, 3 up then down
  typedef struct packed {
    logic [7:0] reps;
    logic [7:0] w;
    logic [1:0] mode;
    logic       wide;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  8'd31, 2'd0, 1'b0, 1'b0, 4'd5}, // R5 large error, clean start
    '{8'd39, 8'd2,  2'd0, 1'b0, 1'b0, 4'd2}, // R2 39 good: no lock
    '{8'd1,  8'd3,  2'd1, 1'b0, 1'b0, 4'd3}, // R3 error 3 breaks run
    '{8'd39, 8'd2,  2'd1, 1'b0, 1'b0, 4'd3}, // R3 run restarted
    '{8'd1,  8'd2,  2'd0, 1'b0, 1'b1, 4'd2}, // R2 40th good: lock
    '{8'd1,  8'd30, 2'd0, 1'b0, 1'b1, 4'd5}, // R5 30 is not large
    '{8'd1,  8'd5,  2'd1, 1'b0, 1'b1, 4'd7}, // R7 mid keeps lock
    '{8'd1,  8'd31, 2'd1, 1'b0, 1'b0, 4'd5}, // R5 31 drops lock
    '{8'd39, 8'd9,  2'd0, 1'b1, 1'b0, 4'd4}, // R4 9 good in wide
    '{8'd1,  8'd10, 2'd0, 1'b1, 1'b0, 4'd4}, // R4 10 breaks run
    '{8'd40, 8'd9,  2'd1, 1'b1, 1'b1, 4'd4}, // R4 wide lock
    '{8'd1,  8'd45, 2'd0, 1'b1, 1'b0, 4'd8}, // R8 saturates: large
    '{8'd40, 8'd1,  2'd3, 1'b0, 1'b1, 4'd9}, // R9 up+down sum 2: good
    '{8'd1,  8'd16, 2'd2, 1'b0, 1'b1, 4'd9}  // R9 overlap counted once: mid
  };

  task automatic check(input logic exp, input string tag);
    n_cmp++;
    if (lock_o !== exp) begin
      n_bad++;
      $display("FAIL %s: lock_o=%b expected %b", tag, lock_o, exp);
    end
  endtask

  // one reference period; inputs change at negedge
  task automatic run_period(input int w, input int mode, input logic wide);
    int len = (mode == 3) ? 2 * w + 2 : w + 2;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wide_win_i   = wide;
      up_i         = (mode != 1 && i < w) ? 1'b1 : 1'b0;
      dn_i         = ((mode == 1 || mode == 2) && i < w) ||
                     (mode == 3 && i >= w && i < 2 * w);
      period_end_i = (i == len - 1);
    end
    @(negedge clk);
    up_i = 1'b0; dn_i = 1'b0; period_end_i = 1'b0;
  endtask

  // evaluation cycle follows; sample after its edge
  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up_i = 0; dn_i = 0; period_end_i = 0; wide_win_i = 0; chan_new_i = 0;
    repeat (3) @(negedge clk);
    check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 after reset");

    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < int'(VECS[v].reps); r++)
        run_period(int'(VECS[v].w), int'(VECS[v].mode), VECS[v].wide);
      settle();
      check(VECS[v].exp, $sformatf("R%0d vector %0d", VECS[v].req, v));
    end

    // R6 channel strobe drops an established lock
    chan_new_i = 1'b1; @(negedge clk); chan_new_i = 1'b0;
    check(1'b0, "R6 strobe while locked");

    // R6 strobe collides with evaluation of the 40th good period
    for (int r = 0; r < 39; r++) run_period(2, 0, 1'b0);
    run_period(2, 0, 1'b0);          // period_end already registered
    chan_new_i = 1'b1;               // evaluation cycle
    @(negedge clk); chan_new_i = 1'b0;
    check(1'b0, "R6 strobe beats evaluation");
    run_period(2, 0, 1'b0); settle();
    check(1'b0, "R6 run was cleared");
    for (int r = 0; r < 39; r++) run_period(2, 0, 1'b0);
    settle();
    check(1'b1, "R6 relock after full run");

    // R1 reset in the middle of a lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 reset clears lock");
    rst_n = 1'b1;
    run_period(2, 0, 1'b0); settle();
    check(1'b0, "R1 run empty after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule